// File: doc/BRIEF.md
# Alignment-Aware Memory Access Unit

This unit connects a core's load/store port to a 32-bit, word-addressed memory. A request carries a byte address, an access size in bytes, a read/write flag, store data, a sign flag for loads, an endianness select and a misalignment-policy select. The unit checks whether the access is legal and aligned. It then either rejects the access with a trap, issues one word access, or, when the policy allows it and the access crosses a word boundary, issues two consecutive word accesses. It places the bytes in the correct lanes for the selected byte order and merges them back for loads.

Each side uses a valid/ready handshake, and only one request is in flight at a time. The memory accepts an access on `mem_valid && mem_ready` and returns read data on `mem_rdata` in the cycle after it accepts. A response is either load data, zero for a completed store, or a trap flag with zero data.

Top module: `mem_align_unit`

## Requirements
- R1: `req_size` holds the access size as a byte count. Only the values 1, 2 and 4 are legal, and any other value traps. An access of size s at address A is aligned when A mod s is 0, so every byte access is aligned.
- R2: With `allow_misaligned`=0, a misaligned access traps. A trapped request makes no memory access, and its response comes one cycle after acceptance with `rsp_trap`=1 and `rsp_rdata`=0.
- R3: With `allow_misaligned`=1, a misaligned access that crosses a word boundary is serviced as two accesses, first word W=A>>2 and then word W+1. A misaligned access that stays inside one word uses one access.
- R4: An access that needs one word makes exactly one memory access. With `mem_ready` held high, its response comes 3 cycles after acceptance. A split access comes 4 cycles after acceptance.
- R5: With `big_endian`=0, byte address a sits in word lane a mod 4, at bits 8*(a mod 4)+7 down to 8*(a mod 4). The byte at an address ending in binary 00 is therefore the least significant byte.
- R6: With `big_endian`=1, byte address a sits in word lane 3-(a mod 4). The byte at an address ending in binary 00 is therefore the most significant byte.
- R7: In little-endian mode the lowest-addressed byte is the least significant byte of the data value. In big-endian mode it is the most significant byte.
- R8: A store sets `mem_write`=1. Its `mem_be` bit k is set exactly when the store writes lane k of that word. Other bytes of memory stay unchanged.
- R9: A load returns the merged value extended to 32 bits. With `req_signed`=1 the value is sign-extended from bit 8*size-1; otherwise it is zero-extended. A store response returns zero data.
- R10: `req_ready` is high only when the unit is idle. A memory request holds its address, data and enables until `mem_ready`. A response holds until `rsp_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle, request accepted this cycle if valid |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 3 | Access size in bytes (1, 2, 4 legal) |
| req_write | input | 1 | 1 = store, 0 = load |
| req_wdata | input | 32 | Store value, right-aligned |
| req_signed | input | 1 | Sign-extend load result |
| big_endian | input | 1 | Byte order select |
| allow_misaligned | input | 1 | 1 = split misaligned accesses, 0 = trap them |
| mem_valid | output | 1 | Memory access request |
| mem_ready | input | 1 | Memory accepts access |
| mem_addr | output | ADDR_W-2 | Word address |
| mem_write | output | 1 | Access is a write |
| mem_be | output | 4 | Byte lane enables |
| mem_wdata | output | 32 | Write word, lanes placed |
| mem_rdata | input | 32 | Read word, one cycle after acceptance |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response consumed |
| rsp_rdata | output | 32 | Extended load value or zero |
| rsp_trap | output | 1 | Request was rejected |

## Verification
The main sweep runs every size code from 0 to 7 at eight consecutive byte offsets, under both policies, both byte orders, as loads and stores, signed and unsigned. It tells illegal sizes from legal ones, traps from splits, and crossing from non-crossing misaligned accesses. It checks each by its cycle count and its number of memory accesses. The load results and the whole memory image after each store tell lane placement, value byte order, enables and extension apart. A second pass with a stalling memory and a held-off response confirms that results do not depend on handshake timing.

// File: rtl/mau_pkg.sv
// Shared definitions for the alignment-aware memory access unit.
// Assumes a 32-bit data word made of four byte lanes.
package mau_pkg;
    localparam int WORD_BYTES = 4;
    localparam int WORD_BITS  = 8 * WORD_BYTES;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE0,
        ST_ISSUE1,
        ST_DRAIN,
        ST_RESP
    } mau_state_t;

    // Physical lane of a byte given its offset inside the word and the byte order.
    function automatic logic [1:0] phys_lane(input logic [1:0] lane, input logic big);
        return big ? (2'd3 - lane) : lane;
    endfunction
endpackage

// File: rtl/mau_check.sv
// Legality and alignment check for one request.
// Assumes size is a byte count; only 1, 2 and 4 are legal.
module mau_check (
    input  logic [1:0] off,
    input  logic [2:0] size,
    input  logic       allow_mis,
    output logic       trap,
    output logic       split
);
    logic legal;
    logic mis;

    // Classify the request: illegal size, misaligned, word-crossing.
    always_comb begin
        legal = (size == 3'd1) || (size == 3'd2) || (size == 3'd4);
        case (size)
            3'd2:    mis = off[0];
            3'd4:    mis = (off != 2'd0);
            default: mis = 1'b0;
        endcase
        trap  = !legal || (mis && !allow_mis);
        split = legal && allow_mis && (({1'b0, off} + size) > 3'd4);
    end
endmodule

// File: rtl/mau_store_lanes.sv
// Places store bytes into the lanes of the first and second word.
// Assumes off/size describe a legal access; lanes are don't-care on a trap.
module mau_store_lanes
    import mau_pkg::*;
(
    input  logic [1:0]           off,
    input  logic [2:0]           size,
    input  logic                 big,
    input  logic [WORD_BITS-1:0] wdata,
    output logic [WORD_BYTES-1:0] be0,
    output logic [WORD_BYTES-1:0] be1,
    output logic [WORD_BITS-1:0] wd0,
    output logic [WORD_BITS-1:0] wd1
);
    logic [2:0] pos;
    logic [1:0] lane;
    logic [2:0] vb;

    // Route each access byte to its word, lane and enable bit.
    always_comb begin
        be0  = '0;
        be1  = '0;
        wd0  = '0;
        wd1  = '0;
        pos  = '0;
        lane = '0;
        vb   = '0;
        for (int i = 0; i < WORD_BYTES; i++) begin
            if (3'(i) < size) begin
                pos  = {1'b0, off} + 3'(i);
                lane = phys_lane(pos[1:0], big);
                vb   = big ? (size - 3'd1 - 3'(i)) : 3'(i);
                if (pos[2]) begin
                    be1[lane]          = 1'b1;
                    wd1[8*lane +: 8]   = wdata[8*vb[1:0] +: 8];
                end else begin
                    be0[lane]          = 1'b1;
                    wd0[8*lane +: 8]   = wdata[8*vb[1:0] +: 8];
                end
            end
        end
    end
endmodule

// File: rtl/mau_load_merge.sv
// Gathers load bytes from up to two words and extends the result.
// Assumes word1 is only consulted when the access crosses a word.
module mau_load_merge
    import mau_pkg::*;
(
    input  logic [1:0]           off,
    input  logic [2:0]           size,
    input  logic                 big,
    input  logic                 sgn,
    input  logic [WORD_BITS-1:0] word0,
    input  logic [WORD_BITS-1:0] word1,
    output logic [WORD_BITS-1:0] value
);
    logic [WORD_BITS-1:0] raw;
    logic [2:0]           pos;
    logic [1:0]           lane;
    logic [2:0]           vb;

    // Collect each byte into its value position.
    always_comb begin
        raw  = '0;
        pos  = '0;
        lane = '0;
        vb   = '0;
        for (int i = 0; i < WORD_BYTES; i++) begin
            if (3'(i) < size) begin
                pos  = {1'b0, off} + 3'(i);
                lane = phys_lane(pos[1:0], big);
                vb   = big ? (size - 3'd1 - 3'(i)) : 3'(i);
                raw[8*vb[1:0] +: 8] = pos[2] ? word1[8*lane +: 8] : word0[8*lane +: 8];
            end
        end
    end

    // Extend the merged value to a full word.
    always_comb begin
        case (size)
            3'd1:    value = {{24{sgn & raw[7]}},  raw[7:0]};
            3'd2:    value = {{16{sgn & raw[15]}}, raw[15:0]};
            default: value = raw;
        endcase
    end
endmodule

// File: rtl/mem_align_unit.sv
// Alignment-aware load/store unit in front of a word-addressed memory.
// Assumes one request in flight, and read data one cycle after memory acceptance.
module mem_align_unit
    import mau_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [2:0]            req_size,
    input  logic                  req_write,
    input  logic [31:0]           req_wdata,
    input  logic                  req_signed,
    input  logic                  big_endian,
    input  logic                  allow_misaligned,
    output logic                  mem_valid,
    input  logic                  mem_ready,
    output logic [ADDR_W-3:0]     mem_addr,
    output logic                  mem_write,
    output logic [3:0]            mem_be,
    output logic [31:0]           mem_wdata,
    input  logic [31:0]           mem_rdata,
    output logic                  rsp_valid,
    input  logic                  rsp_ready,
    output logic [31:0]           rsp_rdata,
    output logic                  rsp_trap
);
    localparam int WADDR_W = ADDR_W - 2;

    mau_state_t           st;
    logic [ADDR_W-1:0]    q_addr;
    logic [2:0]           q_size;
    logic                 q_write;
    logic [WORD_BITS-1:0] q_wdata;
    logic                 q_signed;
    logic                 q_big;
    logic                 q_trap;
    logic                 q_split;
    logic                 pend0;
    logic                 pend1;
    logic [WORD_BITS-1:0] word0;
    logic [WORD_BITS-1:0] word1;

    logic                 chk_trap;
    logic                 chk_split;
    logic [WORD_BYTES-1:0] be0, be1;
    logic [WORD_BITS-1:0] wd0, wd1;
    logic [WORD_BITS-1:0] load_val;
    logic                 accept;

    mau_check u_check (
        .off       (req_addr[1:0]),
        .size      (req_size),
        .allow_mis (allow_misaligned),
        .trap      (chk_trap),
        .split     (chk_split)
    );

    mau_store_lanes u_store (
        .off   (q_addr[1:0]),
        .size  (q_size),
        .big   (q_big),
        .wdata (q_wdata),
        .be0   (be0),
        .be1   (be1),
        .wd0   (wd0),
        .wd1   (wd1)
    );

    mau_load_merge u_merge (
        .off   (q_addr[1:0]),
        .size  (q_size),
        .big   (q_big),
        .sgn   (q_signed),
        .word0 (word0),
        .word1 (word1),
        .value (load_val)
    );

    assign accept = req_valid && req_ready;

    // Sequence a request through check, one or two accesses, and response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else begin
            case (st)
                ST_IDLE:   if (req_valid) st <= chk_trap ? ST_RESP : ST_ISSUE0;
                ST_ISSUE0: if (mem_ready) st <= q_split ? ST_ISSUE1 : ST_DRAIN;
                ST_ISSUE1: if (mem_ready) st <= ST_DRAIN;
                ST_DRAIN:  st <= ST_RESP;
                ST_RESP:   if (rsp_ready) st <= ST_IDLE;
                default:   st <= ST_IDLE;
            endcase
        end
    end

    // Hold the accepted request for the whole transaction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_addr   <= '0;
            q_size   <= '0;
            q_write  <= 1'b0;
            q_wdata  <= '0;
            q_signed <= 1'b0;
            q_big    <= 1'b0;
            q_trap   <= 1'b0;
            q_split  <= 1'b0;
        end else if (accept) begin
            q_addr   <= req_addr;
            q_size   <= req_size;
            q_write  <= req_write;
            q_wdata  <= req_wdata;
            q_signed <= req_signed;
            q_big    <= big_endian;
            q_trap   <= chk_trap;
            q_split  <= chk_split;
        end
    end

    // Capture read words in the cycle after each memory acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend0 <= 1'b0;
            pend1 <= 1'b0;
            word0 <= '0;
            word1 <= '0;
        end else begin
            pend0 <= (st == ST_ISSUE0) && mem_ready;
            pend1 <= (st == ST_ISSUE1) && mem_ready;
            if (pend0) word0 <= mem_rdata;
            if (pend1) word1 <= mem_rdata;
        end
    end

    // Drive the memory side from the current access slot.
    always_comb begin
        mem_valid = (st == ST_ISSUE0) || (st == ST_ISSUE1);
        mem_write = q_write;
        mem_addr  = q_addr[ADDR_W-1:2] + WADDR_W'(st == ST_ISSUE1);
        mem_be    = (st == ST_ISSUE1) ? be1 : be0;
        mem_wdata = (st == ST_ISSUE1) ? wd1 : wd0;
    end

    // Drive the handshake flags and response payload.
    always_comb begin
        req_ready = (st == ST_IDLE);
        rsp_valid = (st == ST_RESP);
        rsp_trap  = q_trap;
        rsp_rdata = (q_trap || q_write) ? '0 : load_val;
    end
endmodule

// File: rtl/mau_checker.sv
// Protocol and ordering checks for mem_align_unit, bound to every instance.
// Assumes the port names of the unit; observes only, drives nothing.
module mau_checker #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              mem_valid,
    input logic              mem_ready,
    input logic [ADDR_W-3:0] mem_addr,
    input logic              mem_write,
    input logic [3:0]        mem_be,
    input logic [31:0]       mem_wdata,
    input logic              rsp_valid,
    input logic              rsp_ready,
    input logic [31:0]       rsp_rdata,
    input logic              rsp_trap
);
    logic [1:0]        acc_cnt;
    logic [ADDR_W-3:0] last_addr;

    // Count memory accesses made since the last accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_cnt   <= '0;
            last_addr <= '0;
        end else begin
            if (req_valid && req_ready) acc_cnt <= '0;
            else if (mem_valid && mem_ready && acc_cnt != 2'd3) acc_cnt <= acc_cnt + 2'd1;
            if (mem_valid && mem_ready) last_addr <= mem_addr;
        end
    end

    AST_TRAP_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_trap |-> acc_cnt == 2'd0);                                  // R2
    AST_TRAP_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_trap |-> rsp_rdata == 32'd0);                               // R2
    AST_ACCESS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_trap |-> (acc_cnt == 2'd1) || (acc_cnt == 2'd2));          // R4
    AST_SECOND_WORD_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && acc_cnt == 2'd1 |-> mem_addr == last_addr + 1'b1);              // R3
    AST_STORE_HAS_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && mem_write |-> mem_be != 4'd0);                                  // R8
    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_be)
            && $stable(mem_wdata) && $stable(mem_write));                            // R10
    AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata) && $stable(rsp_trap)); // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_valid && !rsp_valid);                                     // R10
endmodule

bind mem_align_unit mau_checker #(.ADDR_W(ADDR_W)) u_mau_checker (.*);

// File: tb/mem_align_unit_bench.sv
module mem_align_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [15:0] req_addr = '0;
    logic [2:0]  req_size = '0;
    logic        req_write = 1'b0;
    logic [31:0] req_wdata = '0;
    logic        req_signed = 1'b0;
    logic        big_endian = 1'b0;
    logic        allow_misaligned = 1'b0;
    logic        mem_valid;
    logic        mem_ready = 1'b1;
    logic [13:0] mem_addr;
    logic        mem_write;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b1;
    logic [31:0] rsp_rdata;
    logic        rsp_trap;

    int checks = 0;
    int fails  = 0;
    int acc_count = 0;
    bit stall_mode = 1'b0;
    int stall_ctr = 0;
    logic [31:0] bmem [16];

    always #5 clk = ~clk;

    mem_align_unit u_mem_align_unit (.*);

    // Word memory model: read data one cycle after acceptance, byte-enabled writes.
    always @(posedge clk) begin
        if (mem_valid && mem_ready) begin
            acc_count <= acc_count + 1;
            if (mem_write) begin
                for (int k = 0; k < 4; k++)
                    if (mem_be[k]) bmem[mem_addr[3:0]][8*k +: 8] <= mem_wdata[8*k +: 8];
            end else begin
                mem_rdata <= bmem[mem_addr[3:0]];
            end
        end
    end

    // Stalling pattern for the memory ready input.
    always @(negedge clk) begin
        stall_ctr <= stall_ctr + 1;
        mem_ready <= stall_mode ? ((stall_ctr % 3) == 2) : 1'b1;
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    function automatic logic [1:0] lane_of(input int a, input bit big);
        return big ? 2'(3 - (a % 4)) : 2'(a % 4);
    endfunction

    function automatic int vpos(input int i, input int sz, input bit big);
        return big ? (sz - 1 - i) : i;
    endfunction

    task automatic do_req(input logic [15:0] a, input logic [2:0] sz, input bit wr,
                          input logic [31:0] wd, input bit sg, input bit big, input bit pol,
                          output int cyc, output logic [31:0] rd, output logic tr, output int nacc);
        int base;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_size = sz; req_write = wr;
        req_wdata = wd; req_signed = sg; big_endian = big; allow_misaligned = pol;
        while (!req_ready) @(negedge clk);
        base = acc_count;
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 1;
        while (!rsp_valid) begin
            @(negedge clk);
            cyc++;
        end
        rd = rsp_rdata;
        tr = rsp_trap;
        nacc = acc_count - base;
    endtask

    task automatic run_one(input int a, input int sz, input bit wr, input logic [31:0] wd,
                           input bit sg, input bit big, input bit pol, input bit timed);
        logic [31:0] snap [16];
        logic [31:0] expw [16];
        logic [31:0] raw, expv, rd;
        logic tr;
        int cyc, nacc;
        bit legal, mis, exp_trap, exp_split;
        legal = (sz == 1) || (sz == 2) || (sz == 4);
        mis = legal && ((a % sz) != 0);
        exp_trap = !legal || (mis && !pol);
        exp_split = !exp_trap && ((a % 4) + sz > 4);
        for (int w = 0; w < 16; w++) snap[w] = bmem[w];
        raw = '0;
        if (!exp_trap)
            for (int i = 0; i < sz; i++)
                raw[8*vpos(i, sz, big) +: 8] = snap[((a + i) / 4) % 16][8*lane_of(a + i, big) +: 8];
        if (sz == 1)      expv = {{24{sg & raw[7]}}, raw[7:0]};
        else if (sz == 2) expv = {{16{sg & raw[15]}}, raw[15:0]};
        else              expv = raw;
        if (exp_trap || wr) expv = '0;
        do_req(16'(a), 3'(sz), wr, wd, sg, big, pol, cyc, rd, tr, nacc);
        check(tr == exp_trap, exp_trap ? "R1 R2 trap flag" : "R1 R3 no-trap flag", 32'(tr), 32'(exp_trap));
        check(nacc == (exp_trap ? 0 : (exp_split ? 2 : 1)), "R3 R4 access count",
              32'(nacc), 32'(exp_trap ? 0 : (exp_split ? 2 : 1)));
        if (timed)
            check(cyc == (exp_trap ? 1 : (exp_split ? 4 : 3)), "R2 R4 response latency",
                  32'(cyc), 32'(exp_trap ? 1 : (exp_split ? 4 : 3)));
        check(rd == expv, wr ? "R2 R9 response data" : "R5 R6 R7 R9 load value", rd, expv);
        if (wr) begin
            @(negedge clk);
            for (int w = 0; w < 16; w++) expw[w] = snap[w];
            if (!exp_trap)
                for (int i = 0; i < sz; i++)
                    expw[((a + i) / 4) % 16][8*lane_of(a + i, big) +: 8] = wd[8*vpos(i, sz, big) +: 8];
            for (int w = 0; w < 16; w++)
                check(bmem[w] == expw[w], "R5 R6 R7 R8 memory after store", bmem[w], expw[w]);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        for (int w = 0; w < 16; w++) bmem[w] = 32'h80F1_7E02 ^ (32'(w) * 32'h0103_0507);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(req_ready == 1'b1, "R10 reset ready", 32'(req_ready), 32'd1);
        check(mem_valid == 1'b0, "R10 reset mem idle", 32'(mem_valid), 32'd0);
        check(rsp_valid == 1'b0, "R10 reset no response", 32'(rsp_valid), 32'd0);
        rst_n = 1'b1;

        // Main sweep: sizes 0..7, offsets over two words, policies, byte orders, kinds.
        for (int big = 0; big < 2; big++)
            for (int pol = 0; pol < 2; pol++)
                for (int sz = 0; sz < 8; sz++)
                    for (int off = 0; off < 8; off++)
                        for (int wr = 0; wr < 2; wr++)
                            for (int sg = 0; sg < 2; sg++)
                                run_one(16 + off, sz, wr[0],
                                        32'hA5C3_1E70 ^ (32'(off * 16 + sz * 4 + sg) * 32'h9E37_79B9),
                                        sg[0], big[0], pol[0], 1'b1);

        // Stalling memory: results must match regardless of handshake timing.
        stall_mode = 1'b1;
        for (int big = 0; big < 2; big++)
            for (int off = 0; off < 4; off++)
                for (int wr = 0; wr < 2; wr++)
                    run_one(40 + off, 4, wr[0], 32'h1234_5678 + 32'(off), 1'b1, big[0], 1'b1, 1'b0);
        stall_mode = 1'b0;

        // Response back-pressure: response holds until consumed (R10).
        begin
            logic [31:0] rd0;
            logic tr0;
            int cyc0, n0;
            rsp_ready = 1'b0;
            do_req(16'd21, 3'd2, 1'b0, 32'd0, 1'b0, 1'b0, 1'b1, cyc0, rd0, tr0, n0);
            repeat (3) @(negedge clk);
            check(rsp_valid == 1'b1, "R10 response held", 32'(rsp_valid), 32'd1);
            check(rsp_rdata == rd0, "R10 response data stable", rsp_rdata, rd0);
            check(req_ready == 1'b0, "R10 no new request while busy", 32'(req_ready), 32'd0);
            rsp_ready = 1'b1;
            @(negedge clk);
            check(rsp_valid == 1'b0, "R10 response consumed", 32'(rsp_valid), 32'd0);
        end

        repeat (2) @(negedge clk);
        summary();
        $finish;
    end
endmodule